// File: doc/BRIEF.md
# Table-Driven Serial Clock Generator

This block makes the serial clock for an SPI master. A 5-bit rate index selects a divisor from a fixed series that grows alternately by a factor of 4/3 and 3/2: 3, 4, 6, 8, 12, 16 and so on up to 1024. The input clock is divided by that ratio. Odd ratios are supported, so divide-by-3 works. Each serial clock period starts with a stretch at the idle level and ends with a stretch at the active level. The idle level is chosen by a polarity input.

Besides the clock, the block gives the shift engine two one-cycle strobes. One marks the leading edge, where the clock leaves its idle level. The other marks the trailing edge, where it returns. The shift engine uses them as shift and sample enables, depending on its phase setting. The clock runs only while both the block enable and the transfer request are high. Otherwise it rests at the idle level and its counter is cleared. The rate index is captured while the clock is idle. During a transfer a new index is taken only on a trailing edge that coincides with the word-end flag.

Top module: `spi_lutdiv_clkgen`

## Requirements
- R1: For an effective index e from 2 to MAX_IDX, the serial clock period in input cycles is the series value: 3 for e=1, and each next entry is the previous one times 4/3 (even e) or times 3/2 (odd e). This gives 4, 6, 8, 12, …, 768, 1024 at e=18.
- R2: Index 0 is reserved and behaves as index 2 (divide by 4). Index 1 gives divide by 3 only while `div3_ok` is 1; with `div3_ok` at 0 it also behaves as index 2.
- R3: A requested index above MAX_IDX (default 18) is clamped to MAX_IDX.
- R4: Each period of divisor D has floor(D/2) cycles at the idle level followed by ceil(D/2) cycles at the active level. For D=3 the active stretch is 2 cycles and the idle stretch 1.
- R5: While `en` or `xfer` is 0, `sclk` equals `cpol` and neither strobe is asserted. This holds from the cycle after either input falls.
- R6: After `en` and `xfer` are both high, the first leading edge appears floor(D/2) cycles later. The counter restarts on every idle-to-run transition.
- R7: `lead_stb` is high for exactly one cycle: the first cycle in which `sclk` is at the active level. `trail_stb` is high for exactly one cycle: the first cycle back at the idle level. The two strobes are never high together.
- R8: While running, a change on `rate_idx` or `div3_ok` is ignored until a trailing edge is produced while `word_end` is 1. The next period then uses the new index.
- R9: `cpol`=0 gives an idle-low clock and `cpol`=1 gives an idle-high clock, for every divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable |
| xfer | input | 1 | Transfer in progress; the clock runs while this and `en` are high |
| cpol | input | 1 | Idle level of `sclk` |
| div3_ok | input | 1 | Permits index 1 (divide by 3) |
| rate_idx | input | IDX_W | Requested rate index |
| word_end | input | 1 | Word boundary; allows an index reload at a trailing edge |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the leading edge |
| trail_stb | output | 1 | One-cycle strobe on the trailing edge |

## Verification
The assertions assume that `cpol` changes only while the clock is stopped. The check tying every `sclk` change to a strobe excludes cycles where `cpol` moved. The bench changes polarity, rate index and `div3_ok` only with `xfer` low, at least two cycles before starting a run, so the captured index has settled. The one exception is the word-boundary test, which deliberately changes `rate_idx` in the middle of a run. There are no data-flow interfaces, so no back-pressure rules apply.

// File: rtl/spi_lutdiv_pkg.sv
package spi_lutdiv_pkg;
  // Series value for an index: odd -> 3*2^((i-1)/2), even -> 2^(i/2+1); index 0 reserved.
  function automatic int unsigned lut_div(input int unsigned idx);
    if (idx == 0) return 0;
    if (idx[0]) return 3 << ((idx - 1) / 2);
    return 1 << (idx / 2 + 1);
  endfunction
endpackage

// File: rtl/spi_lutdiv_rate.sv
module spi_lutdiv_rate
  import spi_lutdiv_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAX_IDX = 18,
  parameter int DIV_W   = 11,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             reload,
  input  logic             div3_ok,
  input  logic [IDX_W-1:0] rate_idx,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);
  localparam logic [IDX_W-1:0] MIN_IDX = IDX_W'(2);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_IDX);

  logic [IDX_W-1:0] eff_idx, cur_idx;
  logic [DIV_W-1:0] div;

  always_comb begin
    if (rate_idx > TOP_IDX)                      eff_idx = TOP_IDX;
    else if (rate_idx == IDX_W'(1) && div3_ok)   eff_idx = rate_idx;
    else if (rate_idx < MIN_IDX)                 eff_idx = MIN_IDX;
    else                                         eff_idx = rate_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cur_idx <= MIN_IDX;
    else if (!go || reload)   cur_idx <= eff_idx;
  end

  always_comb begin
    div    = DIV_W'(lut_div(32'(cur_idx)));
    lo_len = CNT_W'(div >> 1);
    hi_len = CNT_W'(div - (div >> 1));
  end
endmodule

// File: rtl/spi_lutdiv_phase.sv
module spi_lutdiv_phase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cpol,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic             act;
  logic             seg_end;

  assign seg_end = act ? (cnt == hi_len - 1'b1) : (cnt == lo_len - 1'b1);
  assign wrap    = go & act & seg_end;
  assign sclk    = cpol ^ act;

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      cnt       <= '0;
      act       <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= !act && seg_end;
      trail_stb <= act && seg_end;
      if (seg_end) begin
        cnt <= '0;
        act <= !act;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_lutdiv_clkgen.sv
module spi_lutdiv_clkgen
  import spi_lutdiv_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int MAX_IDX = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             xfer,
  input  logic             cpol,
  input  logic             div3_ok,
  input  logic [IDX_W-1:0] rate_idx,
  input  logic             word_end,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int DIV_W = $clog2(lut_div(MAX_IDX)) + 1;
  localparam int CNT_W = DIV_W - 1;

  logic             go, wrap;
  logic [CNT_W-1:0] lo_len, hi_len;

  assign go = en & xfer;

  spi_lutdiv_rate #(
    .IDX_W(IDX_W), .MAX_IDX(MAX_IDX), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .go(go), .reload(wrap & word_end),
    .div3_ok(div3_ok), .rate_idx(rate_idx), .lo_len(lo_len), .hi_len(hi_len)
  );

  spi_lutdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .go(go), .cpol(cpol),
    .lo_len(lo_len), .hi_len(hi_len), .sclk(sclk),
    .lead_stb(lead_stb), .trail_stb(trail_stb), .wrap(wrap)
  );
endmodule

// File: rtl/spi_lutdiv_chk.sv
module spi_lutdiv_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic xfer,
  input logic cpol,
  input logic sclk,
  input logic lead_stb,
  input logic trail_stb
);
  logic go;
  assign go = en & xfer;

  AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (sclk == cpol && !lead_stb && !trail_stb)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb)); // R7
  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != cpol)); // R7
  AST_TRAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sclk == cpol)); // R9
  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb); // R7
  AST_EDGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go) && $stable(cpol) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb)); // R4
endmodule

bind spi_lutdiv_clkgen spi_lutdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .xfer(xfer), .cpol(cpol),
  .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/spi_lutdiv_clkgen_bench.sv
module spi_lutdiv_clkgen_bench;
  localparam int MAXI = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, xfer = 1'b0, cpol = 1'b0, div3_ok = 1'b0, word_end = 1'b0;
  logic [4:0] rate_idx = 5'd2;
  logic sclk, lead_stb, trail_stb;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  spi_lutdiv_clkgen #(.IDX_W(5), .MAX_IDX(MAXI)) u_spi_lutdiv_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .xfer(xfer), .cpol(cpol),
    .div3_ok(div3_ok), .rate_idx(rate_idx), .word_end(word_end),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Divisor from the series: start at 3, alternately x4/3 and x3/2.
  function automatic int exp_div(input int idx, input bit d3);
    int e = idx;
    int d = 3;
    if (e > MAXI) e = MAXI;
    if (e == 0 || (e == 1 && !d3)) e = 2;
    for (int i = 2; i <= e; i++) d = (i % 2 == 0) ? d * 4 / 3 : d * 3 / 2;
    return d;
  endfunction

  task automatic run_case(input int idx, input bit d3, input bit pol);
    int d = exp_div(idx, d3);
    int lo = d / 2;
    int hi = d - lo;
    int first_lead = -1, trail_at = -1, second_lead = -1;
    int nlead = 0, ntrail = 0, bad_lvl = 0;
    string tag = (idx < 2) ? "R2" : ((idx > MAXI) ? "R3" : "R1");
    @(negedge clk);
    en = 1'b1; xfer = 1'b0; cpol = pol; div3_ok = d3; rate_idx = 5'(idx);
    @(negedge clk); @(negedge clk);
    chk(sclk == pol && !lead_stb && !trail_stb, "R9 idle level", int'(sclk), int'(pol));
    xfer = 1'b1;
    for (int n = 1; n <= d + lo; n++) begin
      bit exp_act;
      @(negedge clk);
      exp_act = (n >= lo) && (((n - lo) % d) < hi);
      if (sclk != (pol ^ exp_act)) bad_lvl++;
      if (lead_stb) begin
        nlead++;
        if (first_lead < 0) first_lead = n; else second_lead = n;
      end
      if (trail_stb) begin ntrail++; trail_at = n; end
    end
    chk(first_lead == lo, "R6 first leading edge", first_lead, lo);
    chk(trail_at == d, {tag, " trailing edge"}, trail_at, d);
    chk(second_lead == d + lo, {tag, " period"}, second_lead, d + lo);
    chk(bad_lvl == 0, "R4 level pattern mismatches", bad_lvl, 0);
    chk(nlead == 2 && ntrail == 1, "R7 strobe count", nlead * 10 + ntrail, 21);
    xfer = 1'b0;
    @(negedge clk);
    chk(sclk == pol && !lead_stb && !trail_stb, "R5 stop to idle", int'(sclk), int'(pol));
  endtask

  initial begin
    #1_900_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R5 reset state", int'(sclk), 0);

    // Sweep every index, varying div3 permission and polarity.
    for (int i = 0; i < 32; i++) run_case(i, bit'(i % 2), bit'((i / 2) % 2));
    run_case(1, 1'b0, 1'b0);  // R2 index 1 without permission
    run_case(1, 1'b1, 1'b1);  // R2 divide by 3, idle high
    run_case(0, 1'b1, 1'b1);  // R2 reserved index
    run_case(31, 1'b0, 1'b0); // R3 clamp

    // R5: enable low with xfer high keeps the clock parked.
    begin
      int strobes = 0, lvl = 0;
      @(negedge clk);
      en = 1'b0; xfer = 1'b1; cpol = 1'b1; rate_idx = 5'd2;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (lead_stb || trail_stb) strobes++;
        if (sclk != 1'b1) lvl++;
      end
      chk(strobes == 0, "R5 no strobes while disabled", strobes, 0);
      chk(lvl == 0, "R5 idle-high while disabled", lvl, 0);
      xfer = 1'b0; en = 1'b1;
    end

    // R8: index change honoured only at a trailing edge with word_end.
    begin
      int tt[8];
      int k = 0;
      @(negedge clk);
      cpol = 1'b0; div3_ok = 1'b0; rate_idx = 5'd4; word_end = 1'b0;
      @(negedge clk); @(negedge clk);
      xfer = 1'b1;
      for (int n = 1; n <= 37; n++) begin
        @(negedge clk);
        if (trail_stb && k < 8) begin tt[k] = n; k++; end
        if (n == 8)  rate_idx = 5'd2;
        if (n == 20) word_end = 1'b1;
        if (n == 24) word_end = 1'b0;
      end
      xfer = 1'b0;
      chk(k >= 5, "R8 trailing edges seen", k, 6);
      chk(tt[1] == 16, "R8 change ignored mid-word", tt[1], 16);
      chk(tt[2] == 24, "R8 old rate kept until boundary", tt[2], 24);
      chk(tt[3] == 28, "R8 new rate after boundary", tt[3], 28);
      chk(tt[4] == 32, "R8 new rate steady", tt[4], 32);
    end

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule